// File: doc/BRIEF.md
# Shared Peripheral Bus Arbiter

This block lets up to sixteen masters share one single-clock peripheral bus. Each master raises a request line and then watches its own grant line. The arbiter chooses one requester and registers a one-hot grant for it. The bus then belongs to that master for as long as the master holds its lock line high. A master whose lock is low owns the bus for exactly one cycle, which is a single-cycle transfer. After any tenure ends, the bus is idle for one cycle, and the next winner is chosen from the requests seen in that idle cycle.

A mode input selects the priority scheme at run time. In fixed mode the requester with the lowest index always wins. In least-recently-used mode, a master drops to the bottom of a ranking list when its tenure ends. The ranking list is kept up to date in both modes, so switching modes takes effect at the next arbitration. The shared address, write-data and write-strobe lines are built by AND-OR combining. Every master that is not granted is forced to contribute zeros, so with no owner the bus reads as all zeros.

Top module: `shared_bus_arbiter`

## Requirements
- R1: While reset is low and on the first cycle after it: no grant is asserted, busBusy is 0, and the bus address, write data and write strobe are 0.
- R2: In fixed mode (lruMode = 0), an arbitration grants the requesting master with the lowest index, whatever has happened before.
- R3: In least-recently-used mode (lruMode = 1), an arbitration grants the requester that ranks highest in the list. After reset the list is in index order (master 0 first). When a tenure ends, that master moves to the bottom of the list and the others keep their relative order.
- R4: In every cycle, grantOut is one-hot or all zero. Bit i of grantOut is master i. A grant can only appear in the cycle after the granted master's request was seen while the bus was idle.
- R5: While the owner keeps its lockIn bit high, the grant and busBusy stay unchanged, whatever the other requests are. In the cycle after the owner's lock is seen low, the grant goes to zero. Arbitration happens on the following clock edge.
- R6: With no owner, the bus address, write data and write strobe read 0, even when masters drive nonzero values. With no requests pending, no grant appears.
- R7: While master i is granted, busAddr, busWrData and busWrite equal master i's inputs. Changing the inputs of any other master has no effect on them.
- R8: A master granted with its lock low holds the grant for exactly one cycle.
- R9: In least-recently-used mode with every master requesting continuously and no locks, the grants start from the post-reset order and cycle through all masters in rotation 0, 1, ..., N-1, 0, ... One grant is made every two cycles.
- R10: lruMode is sampled at each arbitration. The ranking list is updated in fixed mode too, so history from fixed mode decides the next LRU choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| lruMode | input | 1 | 0 = fixed priority, 1 = least-recently-used priority |
| reqIn | input | NUM_MASTERS | Per-master bus request |
| lockIn | input | NUM_MASTERS | Per-master hold; keeps the owner's grant while high |
| mAddr | input | NUM_MASTERS*ADDR_W | Packed master addresses, master i at bits i*ADDR_W upward |
| mWrData | input | NUM_MASTERS*DATA_W | Packed master write data, master i at bits i*DATA_W upward |
| mWrite | input | NUM_MASTERS | Per-master write strobe |
| grantOut | output | NUM_MASTERS | One-hot registered grant |
| busBusy | output | 1 | High while any master owns the bus |
| busAddr | output | ADDR_W | AND-OR combined address |
| busWrData | output | DATA_W | AND-OR combined write data |
| busWrite | output | 1 | AND-OR combined write strobe |

## Verification
A corrupted ranking list does not show up until the next arbitration in LRU mode. The bench therefore builds known histories and reads the choice they produce one cycle later on grantOut. A continuous-request rotation would expose a misplaced entry within one round of N grants. A wrong owner register or hold decision appears at once as a grant that changes under lock, or as a missing idle cycle after release. A broken AND-OR gate shows on the same cycle as nonzero bus values while idle, or as bus values that follow a master that is not granted.

// File: rtl/shbus_pkg.sv
package shbus_pkg;
  localparam int MAX_MASTERS = 16;
  localparam int OWNER_W = 4;

  typedef struct packed {
    logic drive;
    logic [OWNER_W-1:0] owner;
  } busCtl_t;
endpackage

// File: rtl/shbus_arb_ctrl.sv
module shbus_arb_ctrl
  import shbus_pkg::*;
#(
  parameter int NUM_MASTERS = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   lruMode,
  input  logic [NUM_MASTERS-1:0] reqIn,
  input  logic [NUM_MASTERS-1:0] lockIn,
  output logic [NUM_MASTERS-1:0] grantOut,
  output busCtl_t                ctlOut
);
  localparam int LAST = NUM_MASTERS - 1;

  logic [NUM_MASTERS-1:0] grantQ;
  logic [OWNER_W-1:0]     ownerQ;
  logic [OWNER_W-1:0]     rankQ    [NUM_MASTERS];
  logic [OWNER_W-1:0]     rankNext [NUM_MASTERS];
  logic [OWNER_W-1:0]     pickIdx;
  logic [OWNER_W-1:0]     posIdx;
  logic                   found;
  logic                   busy;
  logic                   releasing;

  assign busy      = |grantQ;
  assign releasing = busy && ((grantQ & lockIn) == '0);

  // Winner selection: lowest index, or highest rank in the LRU list.
  always_comb begin
    pickIdx = '0;
    found   = 1'b0;
    if (!lruMode) begin
      for (int i = LAST; i >= 0; i--) begin
        if (reqIn[i]) begin
          pickIdx = OWNER_W'(i);
          found   = 1'b1;
        end
      end
    end else begin
      for (int p = LAST; p >= 0; p--) begin
        for (int i = 0; i < NUM_MASTERS; i++) begin
          if (rankQ[p] == OWNER_W'(i) && reqIn[i]) begin
            pickIdx = OWNER_W'(i);
            found   = 1'b1;
          end
        end
      end
    end
  end

  // Ranking list after the owner moves to the bottom.
  always_comb begin
    posIdx = '0;
    for (int p = 0; p < NUM_MASTERS; p++) begin
      if (rankQ[p] == ownerQ) posIdx = OWNER_W'(p);
    end
    for (int p = 0; p < LAST; p++) begin
      rankNext[p] = (OWNER_W'(p) < posIdx) ? rankQ[p] : rankQ[p+1];
    end
    rankNext[LAST] = ownerQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantQ <= '0;
      ownerQ <= '0;
      for (int p = 0; p < NUM_MASTERS; p++) rankQ[p] <= OWNER_W'(p);
    end else if (busy) begin
      if (releasing) begin
        grantQ <= '0;
        for (int p = 0; p < NUM_MASTERS; p++) rankQ[p] <= rankNext[p];
      end
    end else if (found) begin
      grantQ <= NUM_MASTERS'(1) << pickIdx;
      ownerQ <= pickIdx;
    end
  end

  assign grantOut     = grantQ;
  assign ctlOut.drive = busy;
  assign ctlOut.owner = ownerQ;

  assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantQ));

  assert_grant_needs_request_R4: assert property (@(posedge clk) disable iff (!rstN)
    (grantQ != '0 && $past(grantQ) == '0) |-> ((grantQ & $past(reqIn)) == grantQ));

  assert_hold_under_lock_R5: assert property (@(posedge clk) disable iff (!rstN)
    (grantQ != '0 && (grantQ & lockIn) != '0) |=> $stable(grantQ));

  assert_release_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (grantQ != '0 && (grantQ & lockIn) == '0) |=> grantQ == '0);

  assert_idle_stays_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (grantQ == '0 && reqIn == '0) |=> grantQ == '0);
endmodule

// File: rtl/shbus_andor_mux.sv
module shbus_andor_mux
  import shbus_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  busCtl_t                       ctlIn,
  input  logic [NUM_MASTERS*ADDR_W-1:0] mAddr,
  input  logic [NUM_MASTERS*DATA_W-1:0] mWrData,
  input  logic [NUM_MASTERS-1:0]        mWrite,
  output logic [ADDR_W-1:0]             busAddr,
  output logic [DATA_W-1:0]             busWrData,
  output logic                          busWrite
);
  logic [NUM_MASTERS-1:0] selVec;

  genvar g;
  generate
    for (g = 0; g < NUM_MASTERS; g++) begin : g_sel
      assign selVec[g] = ctlIn.drive && (ctlIn.owner == OWNER_W'(g));
    end
  endgenerate

  // Each master is gated by its select, then all are ORed together.
  always_comb begin
    busAddr   = '0;
    busWrData = '0;
    busWrite  = 1'b0;
    for (int i = 0; i < NUM_MASTERS; i++) begin
      busAddr   = busAddr   | (mAddr[i*ADDR_W +: ADDR_W]   & {ADDR_W{selVec[i]}});
      busWrData = busWrData | (mWrData[i*DATA_W +: DATA_W] & {DATA_W{selVec[i]}});
      busWrite  = busWrite  | (mWrite[i] & selVec[i]);
    end
  end

  assert_idle_bus_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    !ctlIn.drive |-> (busAddr == '0 && busWrData == '0 && !busWrite));

  assert_select_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(selVec));
endmodule

// File: rtl/shared_bus_arbiter.sv
module shared_bus_arbiter
  import shbus_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          lruMode,
  input  logic [NUM_MASTERS-1:0]        reqIn,
  input  logic [NUM_MASTERS-1:0]        lockIn,
  input  logic [NUM_MASTERS*ADDR_W-1:0] mAddr,
  input  logic [NUM_MASTERS*DATA_W-1:0] mWrData,
  input  logic [NUM_MASTERS-1:0]        mWrite,
  output logic [NUM_MASTERS-1:0]        grantOut,
  output logic                          busBusy,
  output logic [ADDR_W-1:0]             busAddr,
  output logic [DATA_W-1:0]             busWrData,
  output logic                          busWrite
);
  busCtl_t busCtl;

  shbus_arb_ctrl #(.NUM_MASTERS(NUM_MASTERS)) u_ctrl (
    .clk(clk), .rstN(rstN), .lruMode(lruMode), .reqIn(reqIn),
    .lockIn(lockIn), .grantOut(grantOut), .ctlOut(busCtl)
  );

  shbus_andor_mux #(.NUM_MASTERS(NUM_MASTERS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .clk(clk), .rstN(rstN), .ctlIn(busCtl), .mAddr(mAddr), .mWrData(mWrData),
    .mWrite(mWrite), .busAddr(busAddr), .busWrData(busWrData), .busWrite(busWrite)
  );

  assign busBusy = busCtl.drive;
endmodule

// File: tb/shared_bus_arbiter_test.sv
`timescale 1ns/1ps
module shared_bus_arbiter_test;
  localparam int N = 4;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN;
  logic          lruMode;
  logic [N-1:0]  reqIn, lockIn, mWrite;
  logic [N*AW-1:0] mAddr;
  logic [N*DW-1:0] mWrData;
  logic [N-1:0]  grantOut;
  logic          busBusy, busWrite;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busWrData;

  int checks = 0;
  int fails = 0;

  shared_bus_arbiter #(.NUM_MASTERS(N), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .lruMode(lruMode), .reqIn(reqIn), .lockIn(lockIn),
    .mAddr(mAddr), .mWrData(mWrData), .mWrite(mWrite), .grantOut(grantOut),
    .busBusy(busBusy), .busAddr(busAddr), .busWrData(busWrData), .busWrite(busWrite)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; lruMode = 1'b0; reqIn = '0; lockIn = '0; mWrite = '0;
    mAddr = '0; mWrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // Request once with no lock; return the grant and check the one-cycle tenure.
  task automatic pulse(input logic [N-1:0] mask, output logic [N-1:0] got);
    reqIn = mask;
    @(negedge clk);
    got = grantOut;
    reqIn = '0;
    @(negedge clk);
    check("R8 single-cycle tenure", 64'(grantOut), 64'(0));
  endtask

  task automatic testReset();
    rstN = 1'b0; lruMode = 1'b0; reqIn = '1; lockIn = '0;
    mAddr = '1; mWrData = '1; mWrite = '1;
    repeat (2) @(negedge clk);
    check("R1 grant in reset", 64'(grantOut), 64'(0));
    check("R1 busy in reset", 64'(busBusy), 64'(0));
    check("R1 bus addr in reset", 64'(busAddr), 64'(0));
    doReset();
    check("R1 grant after reset", 64'(grantOut), 64'(0));
    check("R1 write after reset", 64'(busWrite), 64'(0));
  endtask

  task automatic testIdle();
    mAddr = {N{32'hDEAD_BEEF}}; mWrData = {N{32'h1234_5678}}; mWrite = '1;
    reqIn = '0;
    repeat (3) @(negedge clk);
    check("R6 no grant without request", 64'(grantOut), 64'(0));
    check("R6 idle addr zero", 64'(busAddr), 64'(0));
    check("R6 idle data zero", 64'(busWrData), 64'(0));
    check("R6 idle write zero", 64'(busWrite), 64'(0));
    mWrite = '0;
  endtask

  task automatic testFixed();
    logic [N-1:0] g;
    lruMode = 1'b0;
    pulse(4'b1110, g); check("R2 fixed lowest of 1110", 64'(g), 64'(4'b0010));
    pulse(4'b1000, g); check("R2 fixed lone 1000", 64'(g), 64'(4'b1000));
    pulse(4'b1111, g); check("R2 fixed lowest of 1111", 64'(g), 64'(4'b0001));
    pulse(4'b1111, g); check("R2 fixed repeat ignores history", 64'(g), 64'(4'b0001));
  endtask

  task automatic testHold();
    lruMode = 1'b0;
    reqIn = 4'b0010; lockIn = 4'b0010;
    @(negedge clk);
    check("R4 grant after request", 64'(grantOut), 64'(4'b0010));
    reqIn = 4'b0011;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R5 hold under lock", 64'(grantOut), 64'(4'b0010));
      check("R5 busy under lock", 64'(busBusy), 64'(1));
    end
    lockIn = '0; reqIn = 4'b0001;
    @(negedge clk);
    check("R5 idle cycle after release", 64'(grantOut), 64'(0));
    @(negedge clk);
    check("R5 rearbitrate after idle", 64'(grantOut), 64'(4'b0001));
    reqIn = '0;
    @(negedge clk);
    check("R8 released", 64'(grantOut), 64'(0));
  endtask

  task automatic testData();
    for (int i = 0; i < N; i++) begin
      mAddr[i*AW +: AW]   = 32'hA000_0000 + 32'(i * 16);
      mWrData[i*DW +: DW] = 32'h5500_0000 + 32'(i);
    end
    mWrite = 4'b0100;
    reqIn = 4'b0100; lockIn = 4'b0100;
    @(negedge clk);
    check("R7 owner addr", 64'(busAddr), 64'(32'hA000_0020));
    check("R7 owner data", 64'(busWrData), 64'(32'h5500_0002));
    check("R7 owner write", 64'(busWrite), 64'(1));
    mAddr[1*AW +: AW] = 32'hFFFF_FFFF; mAddr[3*AW +: AW] = 32'h0F0F_0F0F;
    mWrData[0 +: DW] = 32'hFFFF_FFFF; mWrite = 4'b1011;
    #0.5;
    check("R7 others no effect addr", 64'(busAddr), 64'(32'hA000_0020));
    check("R7 others no effect data", 64'(busWrData), 64'(32'h5500_0002));
    check("R7 owner write low", 64'(busWrite), 64'(0));
    reqIn = '0; lockIn = '0;
    @(negedge clk);
    check("R6 bus zero after release", 64'(busAddr), 64'(0));
    @(negedge clk);
    mWrite = '0;
  endtask

  task automatic testLru();
    logic [N-1:0] g;
    doReset();
    lruMode = 1'b1;
    pulse(4'b0001, g); check("R3 lru lone 0", 64'(g), 64'(4'b0001));
    pulse(4'b0011, g); check("R3 lru recent user demoted", 64'(g), 64'(4'b0010));
    lruMode = 1'b0;
    pulse(4'b0011, g); check("R10 fixed after lru history", 64'(g), 64'(4'b0001));
    lruMode = 1'b1;
    pulse(4'b1011, g); check("R10 lru uses fixed-mode history", 64'(g), 64'(4'b1000));
  endtask

  task automatic testFair();
    doReset();
    lruMode = 1'b1; lockIn = '0; reqIn = '1;
    for (int k = 0; k < 2 * N; k++) begin
      @(negedge clk);
      check("R9 rotation grant", 64'(grantOut), 64'(4'b0001 << (k % N)));
      @(negedge clk);
      check("R9 gap between grants", 64'(grantOut), 64'(0));
    end
    reqIn = '0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    testReset();
    testIdle();
    testFixed();
    testHold();
    testData();
    testLru();
    testFair();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule